// File: doc/BRIEF.md
# SMBus Alert Responder Slave

This block is the bus-facing slave logic of a sensor. It samples the SMBus clock and data lines, decodes the slave address that a select pin picks, and drives an open-drain alert line whenever the sensing logic raises a request. The block never drives the clock and never stretches it. The data line is modelled as a separate input plus a pull-low enable, and the alert line as a pull-low enable. Register decoding beyond the address phase is not part of this block.

When a master answers the alert, it reads from the alert response address. The block acknowledges that read and sends its own address most significant bit first. While it sends, it checks each released bit against the bus, so several alerting devices can share the line: a device that sees a 0 where it released a 1 has lost and stops driving. A device that gets its whole address across releases its alert and sets its own mask bit. Software can write the mask bit to silence the alert or to enable it again.

Top module: `alert_resp_slave`

## Requirements
- R1: After reset the block does not pull the alert line low, does not pull SDA low, and the mask bit reads 0.
- R2: A high cycle on `alertReq` makes a pending alert that pulls the alert line low while the mask is 0. Writing the mask to 1 releases the line and keeps the alert pending. Writing the mask back to 0 pulls the line low again.
- R3: With `addrSel` at 0 the block acknowledges address 7'h18, and with `addrSel` at 1 it acknowledges address 7'h4E. It acknowledges in either direction (address byte 0x30/0x31 or 0x9C/0x9D) by pulling SDA low during the ninth clock. It leaves every other address unacknowledged.
- R4: The block acknowledges the alert response byte 0x19 (address 7'h0C, read bit 1) only when it is pulling the alert line low and `alertCfg` is 0. The same address with the write bit (0x18) is never acknowledged as an alert response.
- R5: After acknowledging the alert response, the block sends its 7-bit address MSB first followed by a released eighth bit. The master reads 0x31 for select 0 and 0x9D for select 1.
- R6: If SDA is low in a bit where the block released a 1, the block stops driving for the rest of the byte. In that case the alert stays asserted and the mask is left unchanged.
- R7: Once all seven address bits have been sent without a loss, the block releases the alert line, sets the mask bit to 1 and clears the pending alert.
- R8: A STOP (SDA rising while SCL is high) releases SDA and returns the block to idle. A repeated START (SDA falling while SCL is high) begins a new address phase from any state.
- R9: The block starts pulling SDA low only while the synchronised SCL is low. It has no output on SCL.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Active-low reset |
| sclIn | input | 1 | SMBus clock level |
| sdaIn | input | 1 | SMBus data level as seen on the wire |
| sdaPull | output | 1 | 1 pulls SDA low |
| addrSel | input | 1 | Chooses between the two slave addresses |
| alertReq | input | 1 | Alert request from the sensing logic |
| alertCfg | input | 1 | 1 blocks answers to the alert response address |
| maskWrEn | input | 1 | Software write strobe for the mask bit |
| maskWrData | input | 1 | Mask value to write |
| maskBit | output | 1 | Current mask bit |
| alertPull | output | 1 | 1 pulls the alert line low |

## Verification
The bench uses the default parameters: a 7-bit address, two-stage synchronisers, the pair 7'h18 / 7'h4E and the response address 7'h0C. With these values both select settings can be checked against a real acknowledge, and a bench-modelled rival device at 7'h0A beats the block in the third bit. Because the rival's later bits differ from the block's, any leftover drive after the loss would change the byte the master reads. A repeated START between an own-address access and the alert response read is also within reach.

// File: rtl/alert_resp_pkg.sv
package alert_resp_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_WAIT
  } phase_t;

  typedef struct packed {
    logic start;
    logic stop;
    logic sclRise;
    logic sclFall;
  } bus_evt_t;

  typedef struct packed {
    logic cntClr;
    logic cntInc;
    logic rxShift;
    logic txLoad;
    logic txNext;
    logic driveLow;
    logic driveRel;
  } dp_ctrl_t;

endpackage

// File: rtl/alert_resp_dp.sv
module alert_resp_dp
  import alert_resp_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int SYNC_STAGES = 2,
  localparam int BYTE_W     = ADDR_W + 1,
  localparam int CNT_W      = $clog2(BYTE_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [ADDR_W-1:0] myAddr,
  input  dp_ctrl_t          stb,
  output bus_evt_t          evt,
  output logic [BYTE_W-1:0] rxByte,
  output logic [CNT_W-1:0]  bitCnt,
  output logic              txCur,
  output logic              sdaS,
  output logic              sdaPull
);

  logic [SYNC_STAGES-1:0] sclPipe;
  logic [SYNC_STAGES-1:0] sdaPipe;
  logic                   sclS;
  logic                   sclPrev;
  logic                   sdaPrev;
  logic [ADDR_W-1:0]      txRest;

  // bus lines idle high, so the synchronisers reset to 1
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  assign sclS = sclPipe[SYNC_STAGES-1];
  assign sdaS = sdaPipe[SYNC_STAGES-1];

  always_comb begin
    evt.sclRise = sclS & ~sclPrev;
    evt.sclFall = ~sclS & sclPrev;
    evt.start   = sclS & sclPrev & sdaPrev & ~sdaS;
    evt.stop    = sclS & sclPrev & ~sdaPrev & sdaS;
  end

  // receive shifter and bit counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxByte <= '0;
      bitCnt <= '0;
    end else begin
      if (stb.rxShift) rxByte <= {rxByte[BYTE_W-2:0], sdaS};
      if (stb.cntClr)      bitCnt <= '0;
      else if (stb.cntInc) bitCnt <= bitCnt + 1'b1;
    end
  end

  // transmit bit in flight plus the bits still to come; a 1 trails the address
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txCur   <= 1'b1;
      txRest  <= '1;
      sdaPull <= 1'b0;
    end else begin
      if (stb.driveRel) begin
        sdaPull <= 1'b0;
        txCur   <= 1'b1;
      end else if (stb.driveLow) begin
        sdaPull <= 1'b1;
      end else if (stb.txLoad) begin
        txCur   <= myAddr[ADDR_W-1];
        txRest  <= {myAddr[ADDR_W-2:0], 1'b1};
        sdaPull <= ~myAddr[ADDR_W-1];
      end else if (stb.txNext) begin
        txCur   <= txRest[ADDR_W-1];
        txRest  <= {txRest[ADDR_W-2:0], 1'b1};
        sdaPull <= ~txRest[ADDR_W-1];
      end
    end
  end

  // R9
  drive_low_scl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaPull) |-> !sclS);

  // R8
  stop_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    evt.stop |=> !sdaPull);

endmodule

// File: rtl/alert_resp_ctrl.sv
module alert_resp_ctrl
  import alert_resp_pkg::*;
#(
  parameter int                ADDR_W   = 7,
  parameter logic [ADDR_W-1:0] ARA_ADDR = 7'h0C,
  localparam int BYTE_W = ADDR_W + 1,
  localparam int CNT_W  = $clog2(BYTE_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  bus_evt_t          evt,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic [CNT_W-1:0]  bitCnt,
  input  logic              txCur,
  input  logic              sdaS,
  input  logic [ADDR_W-1:0] myAddr,
  input  logic              alertOn,
  input  logic              alertCfg,
  output dp_ctrl_t          stb,
  output logic              winStb,
  output logic              lostStb
);

  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] ADDR_CNT = CNT_W'(ADDR_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(ADDR_W - 1);

  phase_t state, stateNext;
  logic   isAra, araNext;
  logic   ownHit, araHit;

  assign ownHit = (rxByte[BYTE_W-1:1] == myAddr);
  assign araHit = (rxByte == {ARA_ADDR, 1'b1}) && alertOn && !alertCfg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      isAra <= 1'b0;
    end else begin
      state <= stateNext;
      isAra <= araNext;
    end
  end

  always_comb begin
    stb       = '0;
    winStb    = 1'b0;
    lostStb   = 1'b0;
    stateNext = state;
    araNext   = isAra;
    if (evt.stop) begin
      stateNext    = ST_IDLE;
      stb.driveRel = 1'b1;
    end else if (evt.start) begin
      stateNext    = ST_RX;
      stb.cntClr   = 1'b1;
      stb.driveRel = 1'b1;
    end else begin
      unique case (state)
        ST_RX: begin
          if (evt.sclRise) begin
            stb.rxShift = 1'b1;
            stb.cntInc  = 1'b1;
          end else if (evt.sclFall && bitCnt == FULL_CNT) begin
            if (ownHit || araHit) begin
              stb.driveLow = 1'b1;
              araNext      = araHit;
              stateNext    = ST_ACK;
            end else begin
              stateNext = ST_WAIT;
            end
          end
        end
        ST_ACK: begin
          if (evt.sclFall) begin
            if (isAra) begin
              stb.txLoad = 1'b1;
              stb.cntClr = 1'b1;
              stateNext  = ST_TX;
            end else begin
              stb.driveRel = 1'b1;
              stateNext    = ST_WAIT;
            end
          end
        end
        ST_TX: begin
          if (evt.sclRise) begin
            if (bitCnt < ADDR_CNT && txCur && !sdaS) begin
              lostStb      = 1'b1;
              stb.driveRel = 1'b1;
              stateNext    = ST_WAIT;
            end else begin
              stb.cntInc = 1'b1;
              if (bitCnt == LAST_BIT) winStb = 1'b1;
            end
          end else if (evt.sclFall) begin
            if (bitCnt == FULL_CNT) begin
              stb.driveRel = 1'b1;
              stateNext    = ST_WAIT;
            end else begin
              stb.txNext = 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // R6
  lost_only_tx_chk: assert property (@(posedge clk) disable iff (!rstN)
    lostStb |=> state == ST_WAIT);

endmodule

// File: rtl/alert_resp_slave.sv
module alert_resp_slave
  import alert_resp_pkg::*;
#(
  parameter int                ADDR_W      = 7,
  parameter int                SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] ADDR_LO     = 7'h18,
  parameter logic [ADDR_W-1:0] ADDR_HI     = 7'h4E,
  parameter logic [ADDR_W-1:0] ARA_ADDR    = 7'h0C,
  localparam int BYTE_W = ADDR_W + 1,
  localparam int CNT_W  = $clog2(BYTE_W + 1)
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaPull,
  input  logic addrSel,
  input  logic alertReq,
  input  logic alertCfg,
  input  logic maskWrEn,
  input  logic maskWrData,
  output logic maskBit,
  output logic alertPull
);

  bus_evt_t          evt;
  dp_ctrl_t          stb;
  logic [BYTE_W-1:0] rxByte;
  logic [CNT_W-1:0]  bitCnt;
  logic              txCur;
  logic              sdaS;
  logic              winStb;
  logic              lostStb;
  logic              alertPend;
  logic [ADDR_W-1:0] myAddr;

  assign myAddr = addrSel ? ADDR_HI : ADDR_LO;

  // a won arbitration takes priority over a software write in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskBit   <= 1'b0;
      alertPend <= 1'b0;
    end else begin
      if (winStb)        maskBit <= 1'b1;
      else if (maskWrEn) maskBit <= maskWrData;
      if (winStb)        alertPend <= 1'b0;
      else if (alertReq) alertPend <= 1'b1;
    end
  end

  assign alertPull = alertPend & ~maskBit;

  alert_resp_dp #(
    .ADDR_W     (ADDR_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .sclIn  (sclIn),
    .sdaIn  (sdaIn),
    .myAddr (myAddr),
    .stb    (stb),
    .evt    (evt),
    .rxByte (rxByte),
    .bitCnt (bitCnt),
    .txCur  (txCur),
    .sdaS   (sdaS),
    .sdaPull(sdaPull)
  );

  alert_resp_ctrl #(
    .ADDR_W  (ADDR_W),
    .ARA_ADDR(ARA_ADDR)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .evt     (evt),
    .rxByte  (rxByte),
    .bitCnt  (bitCnt),
    .txCur   (txCur),
    .sdaS    (sdaS),
    .myAddr  (myAddr),
    .alertOn (alertPull),
    .alertCfg(alertCfg),
    .stb     (stb),
    .winStb  (winStb),
    .lostStb (lostStb)
  );

  // R7
  win_masks_chk: assert property (@(posedge clk) disable iff (!rstN)
    winStb |=> maskBit && !alertPull && !alertPend);

  // R4
  win_needs_alert_chk: assert property (@(posedge clk) disable iff (!rstN)
    winStb |-> alertPend);

  // R6
  lost_keeps_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lostStb && !maskWrEn && !alertReq) |=> $stable(maskBit) && $stable(alertPend));

endmodule

// File: tb/alert_resp_slave_test.sv
module alert_resp_slave_test;

  logic clk = 1'b0;
  logic rstN;
  logic sclM, sdaM, compPull;
  logic addrSel, alertReq, alertCfg, maskWrEn, maskWrData;
  logic sdaPull, maskBit, alertPull;
  wire  sdaBus = sdaM & ~sdaPull & ~compPull;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  alert_resp_slave uut (
    .clk       (clk),
    .rstN      (rstN),
    .sclIn     (sclM),
    .sdaIn     (sdaBus),
    .sdaPull   (sdaPull),
    .addrSel   (addrSel),
    .alertReq  (alertReq),
    .alertCfg  (alertCfg),
    .maskWrEn  (maskWrEn),
    .maskWrData(maskWrData),
    .maskBit   (maskBit),
    .alertPull (alertPull)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic q();
    repeat (8) @(negedge clk);
  endtask

  task automatic busBit(input bit mBit, input bit cBit, output bit seen);
    sclM = 1'b0; q();
    sdaM = mBit; compPull = ~cBit; q();
    sclM = 1'b1; q();
    seen = sdaBus; q();
    sclM = 1'b0;
  endtask

  task automatic startCond();
    sdaM = 1'b1; q();
    sclM = 1'b1; q();
    sdaM = 1'b0; q();
    sclM = 1'b0; q();
  endtask

  task automatic stopCond();
    sclM = 1'b0; compPull = 1'b0; sdaM = 1'b0; q();
    sclM = 1'b1; q();
    sdaM = 1'b1; q();
  endtask

  task automatic sendByte(input logic [7:0] b, output bit ack);
    bit seen;
    for (int i = 7; i >= 0; i--) busBit(b[i], 1'b1, seen);
    busBit(1'b1, 1'b1, seen);
    ack = ~seen;
  endtask

  task automatic readByte(input logic [7:0] comp, output logic [7:0] val);
    bit seen;
    for (int i = 7; i >= 0; i--) begin
      busBit(1'b1, comp[i], seen);
      val[i] = seen;
    end
    compPull = 1'b0;
    busBit(1'b1, 1'b1, seen);
  endtask

  task automatic writeMask(input bit v);
    @(negedge clk); maskWrEn = 1'b1; maskWrData = v;
    @(negedge clk); maskWrEn = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic raiseAlert();
    @(negedge clk); alertReq = 1'b1;
    @(negedge clk); alertReq = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic addrAccess(input logic [7:0] b, input bit expAck, input string req);
    bit ack;
    startCond();
    sendByte(b, ack);
    stopCond();
    chk(req, {7'd0, ack}, {7'd0, expAck});
  endtask

  task automatic testReset();
    chk("R1 alert", {7'd0, alertPull}, 8'd0);
    chk("R1 sda", {7'd0, sdaPull}, 8'd0);
    chk("R1 mask", {7'd0, maskBit}, 8'd0);
  endtask

  task automatic testAddrSelect();
    addrSel = 1'b0;
    addrAccess(8'h30, 1'b1, "R3 0x18 write ack");
    addrAccess(8'h31, 1'b1, "R3 0x18 read ack");
    addrAccess(8'h9C, 1'b0, "R3 0x4E nack at sel0");
    chk("R8 released after stop", {7'd0, sdaPull}, 8'd0);
    addrSel = 1'b1;
    addrAccess(8'h9D, 1'b1, "R3 0x4E ack");
    addrAccess(8'h30, 1'b0, "R3 0x18 nack at sel1");
    addrSel = 1'b0;
  endtask

  task automatic testAlertMask();
    raiseAlert();
    chk("R2 alert raised", {7'd0, alertPull}, 8'd1);
    writeMask(1'b1);
    chk("R2 masked", {7'd0, alertPull}, 8'd0);
    chk("R2 mask reads 1", {7'd0, maskBit}, 8'd1);
    writeMask(1'b0);
    chk("R2 unmasked pending", {7'd0, alertPull}, 8'd1);
  endtask

  task automatic testAraGuards();
    alertCfg = 1'b1;
    addrAccess(8'h19, 1'b0, "R4 cfg blocks response");
    alertCfg = 1'b0;
    addrAccess(8'h18, 1'b0, "R4 write bit not answered");
    chk("R4 alert kept", {7'd0, alertPull}, 8'd1);
  endtask

  task automatic testAraLose();
    bit ack;
    logic [7:0] val;
    startCond();
    sendByte(8'h19, ack);
    chk("R4 response acked", {7'd0, ack}, 8'd1);
    readByte(8'h15, val);
    stopCond();
    chk("R6 rival byte", val, 8'h15);
    chk("R6 alert kept", {7'd0, alertPull}, 8'd1);
    chk("R6 mask kept", {7'd0, maskBit}, 8'd0);
  endtask

  task automatic testAraWin(input logic [7:0] expByte, input string req);
    bit ack;
    logic [7:0] val;
    startCond();
    sendByte(8'h19, ack);
    chk("R4 response acked", {7'd0, ack}, 8'd1);
    readByte(8'hFF, val);
    chk(req, val, expByte);
    chk("R7 alert released", {7'd0, alertPull}, 8'd0);
    chk("R7 mask set", {7'd0, maskBit}, 8'd1);
    stopCond();
  endtask

  task automatic testAfterWin();
    addrAccess(8'h19, 1'b0, "R4 no response when masked");
    writeMask(1'b0);
    chk("R7 pending cleared", {7'd0, alertPull}, 8'd0);
    addrAccess(8'h19, 1'b0, "R4 no response without alert");
  endtask

  task automatic testRepStart();
    bit ack;
    logic [7:0] val;
    raiseAlert();
    startCond();
    sendByte(8'h30, ack);
    chk("R8 own ack before restart", {7'd0, ack}, 8'd1);
    startCond();
    sendByte(8'h19, ack);
    chk("R8 response after restart", {7'd0, ack}, 8'd1);
    readByte(8'hFF, val);
    stopCond();
    chk("R8 byte after restart", val, 8'h31);
    chk("R7 mask after restart", {7'd0, maskBit}, 8'd1);
  endtask

  task automatic testSel1Win();
    addrSel = 1'b1;
    writeMask(1'b0);
    raiseAlert();
    testAraWin(8'h9D, "R5 sel1 address sent");
    addrSel = 1'b0;
  endtask

  initial begin
    rstN = 1'b0; sclM = 1'b1; sdaM = 1'b1; compPull = 1'b0;
    addrSel = 1'b0; alertReq = 1'b0; alertCfg = 1'b0;
    maskWrEn = 1'b0; maskWrData = 1'b0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    testReset();
    testAddrSelect();
    testAlertMask();
    testAraGuards();
    testAraLose();
    testAraWin(8'h31, "R5 sel0 address sent");
    testAfterWin();
    testRepStart();
    testSel1Win();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got hang expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule